// File: doc/BRIEF.md
# Flash sector protection controller

This block keeps the software protection state of a 512 KB serial flash array that is cut into eleven sectors of unequal size. It holds one protect bit per sector and a lock bit, and it applies decoded requests from the command front end. The requests are a set-sector request, a clear-sector request, and a status-register write whose data byte can lock the map and can protect or unprotect every sector at once. A write-protect input decides whether a set lock bit may be cleared by software.

The block also answers two questions without delay. The first is whether the sector that holds a given byte address is protected. The second is whether an erase of 4 KB, 32 KB or 64 KB starting at a given address touches any protected sector. It reports a two-bit summary of the whole map. Each request gets an accept or ignore flag one cycle after its strobe. All control and status pins are plain levels and one-cycle strobes, with no handshake. A strobe is always taken in the cycle it is high, so there is no back-pressure.

The sector layout is as follows:
- Sectors 0 to 6 are 64 KB each and cover 0x000000 to 0x06FFFF.
- Sector 7 is 32 KB at 0x070000.
- Sectors 8 and 9 are 8 KB each, at 0x078000 and 0x07A000.
- Sector 10 is 16 KB at 0x07C000.

Top module: `flash_secprot`

## Requirements
- R1: After reset every sector is protected, the lock bit is 0, the summary reads 11 and both result flag vectors are 0.
- R2: query_prot equals the protect bit of the sector that holds query_addr, using the sector layout given above.
- R3: With the lock bit at 0, a set request protects only the sector that holds req_addr, and a clear request unprotects only that sector. Either request raises its accept flag in the following cycle. Flag bit 0 is set, bit 1 is clear and bit 2 is status write.
- R4: With the lock bit at 1, set and clear requests and the global part of a status write change no protect bit, and a set or clear request raises its ignore flag.
- R5: An accepted status write with the lock bit at 0 protects all sectors when data bits 5:2 are 1111, unprotects all sectors when they are 0000, and leaves the map unchanged for any other value. The lock bit takes data bit 7.
- R6: A global operation takes effect in the same write that moves the lock bit from 0 to 1. A write that moves the lock bit from 1 to 0 performs no global operation.
- R7: While wp_asserted is 1 and the lock bit is 1, a status write is ignored and the lock bit stays 1, so only reset can clear it. While wp_asserted is 1 and the lock bit is 0, a status write may still set the lock bit.
- R8: erase_blocked is 1 when any sector that overlaps the aligned erase block is protected. The block size comes from erase_size: 00 is 4 KB, 01 is 32 KB, and 10 or 11 is 64 KB.
- R9: prot_summary reads 00 when no sector is protected, 11 when all are protected and 01 otherwise. It follows the map in the same cycle.
- R10: Strobes in the same cycle are resolved with status write first, then set, then clear. Each losing strobe raises its ignore flag and has no effect.
- R11: Address bits 23:19 are ignored by every address input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_asserted | input | 1 | Write-protect pin level, 1 = asserted |
| set_req | input | 1 | Strobe: protect the sector at req_addr |
| clr_req | input | 1 | Strobe: unprotect the sector at req_addr |
| req_addr | input | 24 | Byte address for set or clear |
| stat_wr | input | 1 | Strobe: status-register write |
| stat_data | input | 8 | Status write data: bit 7 is lock, bits 5:2 are global code |
| query_addr | input | 24 | Byte address to look up |
| query_prot | output | 1 | Sector holding query_addr is protected |
| erase_addr | input | 24 | Any address inside the erase block |
| erase_size | input | 2 | Erase block size code |
| erase_blocked | output | 1 | Erase block overlaps a protected sector |
| lock_bit | output | 1 | Current lock bit |
| prot_summary | output | 2 | Protection summary |
| res_acc | output | 3 | Per request kind: accepted last cycle |
| res_ign | output | 3 | Per request kind: ignored last cycle |

## Verification
The main table sends single set, clear and status-write strobes across the sector types. This separates a wrong sector decode from a wrong update, because neighbouring 8 KB sectors are queried after one of them changes. Status-write data bytes with global codes 1111, 0000 and a mixed value are sent with the lock bit at 0 and at 1, in both lock directions, and with write-protect both high and low. These runs tell the same-write global rule apart from plain lock behaviour. Directed cases follow:
- erase spans that straddle the small sectors near the top of the array;
- addresses with the upper bits set;
- strobes that collide in one cycle;
- a reset taken while write-protect holds the lock.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int ADDR_W   = 24;
  localparam int ARR_AW   = 19;
  localparam int NUM_SECT = 11;
  localparam int N_KIND   = 3;
  localparam int K_SET    = 0;
  localparam int K_CLR    = 1;
  localparam int K_STAT   = 2;
  localparam int LOCK_POS = 7;
  localparam int GLB_LO   = 2;
  localparam int GLB_HI   = 5;

  typedef enum logic [1:0] {
    BLK_4K  = 2'b00,
    BLK_32K = 2'b01,
    BLK_64K = 2'b10,
    BLK_64X = 2'b11
  } blk_e;

  typedef enum logic [1:0] {
    SUM_NONE = 2'b00,
    SUM_SOME = 2'b01,
    SUM_ALL  = 2'b11
  } sum_e;

  // Start byte of each sector; sectors below 7 are 64 KB apart.
  function automatic logic [ARR_AW:0] sect_base(input int idx);
    logic [ARR_AW:0] b;
    if (idx < 7)       b = 20'(idx) << 16;
    else if (idx == 7) b = 20'h70000;
    else if (idx == 8) b = 20'h78000;
    else if (idx == 9) b = 20'h7A000;
    else               b = 20'h7C000;
    return b;
  endfunction

  function automatic logic [ARR_AW:0] sect_size(input int idx);
    logic [ARR_AW:0] s;
    if (idx < 7)       s = 20'h10000;
    else if (idx == 7) s = 20'h08000;
    else if (idx < 10) s = 20'h02000;
    else               s = 20'h04000;
    return s;
  endfunction
endpackage

// File: rtl/fsp_span_decode.sv
module fsp_span_decode
  import fsp_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int IN_AW = ARR_AW,
  parameter int NS    = NUM_SECT
) (
  input  logic [AW-1:0] addr,
  input  blk_e          blk,
  output logic [NS-1:0] hit_mask
);
  localparam int LW = IN_AW + 1;

  logic [LW-1:0] blk_len;
  logic [LW-1:0] blk_lo;
  logic [LW-1:0] blk_hi;
  logic          unused_hi;

  assign unused_hi = ^addr[AW-1:IN_AW];

  always_comb begin
    unique case (blk)
      BLK_4K:  blk_len = LW'(1) << 12;
      BLK_32K: blk_len = LW'(1) << 15;
      default: blk_len = LW'(1) << 16;
    endcase
    blk_lo = {1'b0, addr[IN_AW-1:0]} & ~(blk_len - LW'(1));
    blk_hi = blk_lo + blk_len;
  end

  for (genvar i = 0; i < NS; i++) begin : g_sect
    localparam logic [LW-1:0] S_LO = LW'(sect_base(i));
    localparam logic [LW-1:0] S_HI = LW'(sect_base(i) + sect_size(i));
    assign hit_mask[i] = (blk_lo < S_HI) && (S_LO < blk_hi);
  end
endmodule

// File: rtl/fsp_prot_store.sv
module fsp_prot_store
  import fsp_pkg::*;
#(
  parameter int NS = NUM_SECT,
  parameter int NK = N_KIND
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_asserted,
  input  logic          set_req,
  input  logic          clr_req,
  input  logic [NS-1:0] req_mask,
  input  logic          stat_wr,
  input  logic [7:0]    stat_data,
  output logic [NS-1:0] prot_vec,
  output logic          lock_bit,
  output logic [NK-1:0] res_acc,
  output logic [NK-1:0] res_ign
);
  logic [NS-1:0] prot_nxt;
  logic          lock_nxt;
  logic [NK-1:0] acc_nxt;
  logic [NK-1:0] ign_nxt;
  logic [GLB_HI-GLB_LO:0] glb_code;
  logic          unused_data;

  assign glb_code    = stat_data[GLB_HI:GLB_LO];
  assign unused_data = ^{stat_data[6], stat_data[1:0]};

  always_comb begin
    prot_nxt = prot_vec;
    lock_nxt = lock_bit;
    acc_nxt  = '0;
    ign_nxt  = '0;
    if (stat_wr) begin
      if (lock_bit && wp_asserted) begin
        ign_nxt[K_STAT] = 1'b1;
      end else begin
        acc_nxt[K_STAT] = 1'b1;
        lock_nxt        = stat_data[LOCK_POS];
        if (!lock_bit) begin
          if (&glb_code)      prot_nxt = '1;
          else if (~|glb_code) prot_nxt = '0;
        end
      end
      ign_nxt[K_SET] = set_req;
      ign_nxt[K_CLR] = clr_req;
    end else if (set_req) begin
      if (lock_bit) ign_nxt[K_SET] = 1'b1;
      else begin
        acc_nxt[K_SET] = 1'b1;
        prot_nxt       = prot_vec | req_mask;
      end
      ign_nxt[K_CLR] = clr_req;
    end else if (clr_req) begin
      if (lock_bit) ign_nxt[K_CLR] = 1'b1;
      else begin
        acc_nxt[K_CLR] = 1'b1;
        prot_nxt       = prot_vec & ~req_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_vec <= '1;
      lock_bit <= 1'b0;
      res_acc  <= '0;
      res_ign  <= '0;
    end else begin
      prot_vec <= prot_nxt;
      lock_bit <= lock_nxt;
      res_acc  <= acc_nxt;
      res_ign  <= ign_nxt;
    end
  end
endmodule

// File: rtl/fsp_summary.sv
module fsp_summary
  import fsp_pkg::*;
#(
  parameter int NS = NUM_SECT
) (
  input  logic [NS-1:0] prot_vec,
  output sum_e          summary
);
  always_comb begin
    if (&prot_vec)       summary = SUM_ALL;
    else if (|prot_vec)  summary = SUM_SOME;
    else                 summary = SUM_NONE;
  end
endmodule

// File: rtl/flash_secprot.sv
module flash_secprot
  import fsp_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NS = NUM_SECT,
  parameter int NK = N_KIND
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_asserted,
  input  logic          set_req,
  input  logic          clr_req,
  input  logic [AW-1:0] req_addr,
  input  logic          stat_wr,
  input  logic [7:0]    stat_data,
  input  logic [AW-1:0] query_addr,
  output logic          query_prot,
  input  logic [AW-1:0] erase_addr,
  input  logic [1:0]    erase_size,
  output logic          erase_blocked,
  output logic          lock_bit,
  output logic [1:0]    prot_summary,
  output logic [NK-1:0] res_acc,
  output logic [NK-1:0] res_ign
);
  logic [NS-1:0] prot_vec;
  logic [NS-1:0] req_mask;
  logic [NS-1:0] qry_mask;
  logic [NS-1:0] ers_mask;
  sum_e          summary;

  fsp_span_decode #(.AW(AW), .NS(NS)) u_req_dec (
    .addr(req_addr), .blk(BLK_4K), .hit_mask(req_mask));

  fsp_span_decode #(.AW(AW), .NS(NS)) u_qry_dec (
    .addr(query_addr), .blk(BLK_4K), .hit_mask(qry_mask));

  fsp_span_decode #(.AW(AW), .NS(NS)) u_ers_dec (
    .addr(erase_addr), .blk(blk_e'(erase_size)), .hit_mask(ers_mask));

  fsp_prot_store #(.NS(NS), .NK(NK)) u_store (
    .clk(clk), .rst_n(rst_n), .wp_asserted(wp_asserted),
    .set_req(set_req), .clr_req(clr_req), .req_mask(req_mask),
    .stat_wr(stat_wr), .stat_data(stat_data),
    .prot_vec(prot_vec), .lock_bit(lock_bit),
    .res_acc(res_acc), .res_ign(res_ign));

  fsp_summary #(.NS(NS)) u_sum (.prot_vec(prot_vec), .summary(summary));

  assign query_prot    = |(qry_mask & prot_vec);
  assign erase_blocked = |(ers_mask & prot_vec);
  assign prot_summary  = summary;
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker
  import fsp_pkg::*;
#(
  parameter int NS = NUM_SECT,
  parameter int NK = N_KIND
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wp_asserted,
  input logic          lock_bit,
  input logic [1:0]    prot_summary,
  input logic          query_prot,
  input logic          erase_blocked,
  input logic [NK-1:0] res_acc,
  input logic [NK-1:0] res_ign,
  input logic [NS-1:0] prot_vec
);
  assert_locked_map_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_bit |=> $stable(prot_vec));

  assert_wp_holds_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_bit && wp_asserted) |=> lock_bit);

  assert_acc_ign_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_acc & res_ign) == '0);

  assert_sector_acc_needs_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_acc[K_SET] || res_acc[K_CLR]) |-> $past(!lock_bit));

  assert_summary_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prot_summary != 2'b10);

  assert_none_means_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_summary == SUM_NONE) |-> (!query_prot && !erase_blocked));

  assert_all_means_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_summary == SUM_ALL) |-> (query_prot && erase_blocked));
endmodule

bind flash_secprot fsp_checker #(.NS(NS), .NK(NK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_asserted(wp_asserted), .lock_bit(lock_bit),
  .prot_summary(prot_summary), .query_prot(query_prot),
  .erase_blocked(erase_blocked), .res_acc(res_acc), .res_ign(res_ign),
  .prot_vec(prot_vec));

// File: tb/flash_secprot_bench.sv
module flash_secprot_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  op;    // 0 none, 1 set, 2 clear, 3 status write
    logic        wp;
    logic [23:0] val;
    logic [23:0] qaddr;
    logic        exp_q;
    logic        exp_acc;
    logic        exp_lock;
    logic [1:0]  exp_sum;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd3, 2'd2, 1'b0, 24'h000100, 24'h000100, 1'b0, 1'b1, 1'b0, 2'b01}, // R3
    '{4'd2, 2'd2, 1'b0, 24'h079FFF, 24'h078000, 1'b0, 1'b1, 1'b0, 2'b01}, // R2
    '{4'd2, 2'd0, 1'b0, 24'h000000, 24'h07A000, 1'b1, 1'b0, 1'b0, 2'b01}, // R2
    '{4'd3, 2'd1, 1'b0, 24'h00FFFF, 24'h000000, 1'b1, 1'b1, 1'b0, 2'b01}, // R3
    '{4'd5, 2'd3, 1'b0, 24'h000000, 24'h07C000, 1'b0, 1'b1, 1'b0, 2'b00}, // R5
    '{4'd5, 2'd3, 1'b0, 24'h00003C, 24'h050000, 1'b1, 1'b1, 1'b0, 2'b11}, // R5
    '{4'd3, 2'd2, 1'b0, 24'h070000, 24'h070000, 1'b0, 1'b1, 1'b0, 2'b01}, // R3
    '{4'd5, 2'd3, 1'b0, 24'h000004, 24'h070000, 1'b0, 1'b1, 1'b0, 2'b01}, // R5
    '{4'd6, 2'd3, 1'b0, 24'h000080, 24'h000000, 1'b0, 1'b1, 1'b1, 2'b00}, // R6
    '{4'd4, 2'd1, 1'b0, 24'h000000, 24'h000000, 1'b0, 1'b0, 1'b1, 2'b00}, // R4
    '{4'd4, 2'd3, 1'b0, 24'h0000BC, 24'h060000, 1'b0, 1'b1, 1'b1, 2'b00}, // R4
    '{4'd6, 2'd3, 1'b0, 24'h00003C, 24'h000000, 1'b0, 1'b1, 1'b0, 2'b00}, // R6
    '{4'd7, 2'd3, 1'b1, 24'h0000BC, 24'h07E000, 1'b1, 1'b1, 1'b1, 2'b11}, // R7
    '{4'd7, 2'd3, 1'b1, 24'h000000, 24'h000000, 1'b1, 1'b0, 1'b1, 2'b11}, // R7
    '{4'd4, 2'd2, 1'b1, 24'h000000, 24'h000000, 1'b1, 1'b0, 1'b1, 2'b11}  // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_asserted = 1'b0;
  logic        set_req = 1'b0;
  logic        clr_req = 1'b0;
  logic [23:0] req_addr = '0;
  logic        stat_wr = 1'b0;
  logic [7:0]  stat_data = '0;
  logic [23:0] query_addr = '0;
  logic        query_prot;
  logic [23:0] erase_addr = '0;
  logic [1:0]  erase_size = '0;
  logic        erase_blocked;
  logic        lock_bit;
  logic [1:0]  prot_summary;
  logic [2:0]  res_acc;
  logic [2:0]  res_ign;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_secprot u_flash_secprot (
    .clk(clk), .rst_n(rst_n), .wp_asserted(wp_asserted),
    .set_req(set_req), .clr_req(clr_req), .req_addr(req_addr),
    .stat_wr(stat_wr), .stat_data(stat_data),
    .query_addr(query_addr), .query_prot(query_prot),
    .erase_addr(erase_addr), .erase_size(erase_size),
    .erase_blocked(erase_blocked), .lock_bit(lock_bit),
    .prot_summary(prot_summary), .res_acc(res_acc), .res_ign(res_ign));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive strobes for one cycle from a falling edge; the next falling edge
  // sees the registered flags and the updated map.
  task automatic pulse(input logic s, input logic c, input logic w,
                       input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    set_req = s; clr_req = c; stat_wr = w; req_addr = a; stat_data = d;
    @(negedge clk);
    set_req = 1'b0; clr_req = 1'b0; stat_wr = 1'b0;
  endtask

  task automatic span(input string tag, input logic [23:0] a,
                      input logic [1:0] sz, input logic exp);
    erase_addr = a; erase_size = sz;
    #1;
    chk(tag, erase_blocked, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    query_addr = 24'h07C000; #1;
    chk("R1 lock", lock_bit, 0);
    chk("R1 summary", prot_summary, 2'b11);
    chk("R1 query", query_prot, 1);
    chk("R1 flags", {res_acc, res_ign}, 0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      int k;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      wp_asserted = v.wp;
      pulse(v.op == 2'd1, v.op == 2'd2, v.op == 2'd3, v.val, v.val[7:0]);
      query_addr = v.qaddr; #1;
      chk({tag, " query"}, query_prot, v.exp_q);
      chk({tag, " lock"}, lock_bit, v.exp_lock);
      chk({tag, " summary"}, prot_summary, v.exp_sum);
      if (v.op == 2'd0) chk({tag, " flags"}, {res_acc, res_ign}, 0);
      else begin
        k = int'(v.op) - 1;
        chk({tag, " acc"}, res_acc[k], v.exp_acc);
        chk({tag, " ign"}, res_ign[k], !v.exp_acc);
      end
    end

    // R7: lock held by write protect only leaves through reset; R1 again
    wp_asserted = 1'b1;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R7 reset clears lock", lock_bit, 0);
    chk("R1 summary after reset", prot_summary, 2'b11);
    wp_asserted = 1'b0;

    // R8 erase spans
    pulse(1'b0, 1'b1, 1'b0, 24'h078000, 8'h00);
    pulse(1'b0, 1'b1, 1'b0, 24'h07A000, 8'h00);
    span("R8 32K top, s10 protected", 24'h07BFFF, 2'b01, 1'b1);
    pulse(1'b0, 1'b1, 1'b0, 24'h07C000, 8'h00);
    span("R8 32K top, all open", 24'h07BFFF, 2'b01, 1'b0);
    span("R8 4K inside s10", 24'h07D000, 2'b00, 1'b0);
    span("R8 64K top incl s7", 24'h070000, 2'b10, 1'b1);
    span("R8 size 11 as 64K", 24'h07FFFF, 2'b11, 1'b1);
    pulse(1'b0, 1'b1, 1'b0, 24'h010000, 8'h00);
    span("R8 64K s1 open", 24'h01ABCD, 2'b10, 1'b0);
    span("R8 32K s1 upper", 24'h018000, 2'b01, 1'b0);
    span("R8 32K s2 protected", 24'h020000, 2'b01, 1'b1);

    // R11 upper address bits ignored
    query_addr = 24'hF90000; #1;
    chk("R11 query upper bits", query_prot, 0);
    pulse(1'b0, 1'b1, 1'b0, 24'hE20000, 8'h00);
    query_addr = 24'h020000; #1;
    chk("R11 request upper bits", query_prot, 0);
    span("R11 erase upper bits", 24'hA10000, 2'b10, 1'b0);

    // R10 collisions
    pulse(1'b1, 1'b1, 1'b0, 24'h010000, 8'h00);
    query_addr = 24'h010000; #1;
    chk("R10 set beats clear acc", res_acc, 3'b001);
    chk("R10 set beats clear ign", res_ign, 3'b010);
    chk("R10 set beats clear map", query_prot, 1);
    pulse(1'b0, 1'b1, 1'b1, 24'h050000, 8'h3C);
    query_addr = 24'h050000; #1;
    chk("R10 status beats clear acc", res_acc, 3'b100);
    chk("R10 status beats clear ign", res_ign, 3'b010);
    chk("R10 status beats clear map", query_prot, 1);
    chk("R9 all after global", prot_summary, 2'b11);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule